// File: doc/BRIEF.md
# Fixed-Period PWM Code Generator

This block turns a digital code into a pulse train of constant period whose high or low time is set by that code. The pulse train then drives an external low-pass filter, and the result is a slow analog level. The period, measured in timer ticks, comes from a configuration input. The code arrives through a small valid/ready stream. A select input picks between two output polarities. The number of distinct output levels equals the period count, so a period of 512 ticks gives 9 bits of resolution.

A new code, and any change to period, polarity or band width, is held until the current period ends. All of them take effect together at the next rollover, so the output never shows a truncated or doubled pulse.

The block also reproduces a limit found in fast, clock-multiplied timers. When the active code is very close to either end of its range, the pin stays at the polarity's resting level for the whole period and does not pulse. A single-cycle strobe marks the first tick of every period, so an external update source can align its writes to it.

Top module: `pwm_dac_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pwm_o` is 0 and `period_start_o` is 0.
- R2: With an active period P of 2 or more, the internal tick count runs 0 to P-1 and repeats. `period_start_o` is 1 only in tick 0, so it is high for exactly one cycle in every P.
- R3: In reset/set polarity (`mode_i` = 0), the resting level is 0. Outside the dead bands, `pwm_o` is 1 in ticks 0 to D-1 and 0 from tick D to the end of the period, where D is the active code.
- R4: In set/reset polarity (`mode_i` = 1), the resting level is 1. Outside the dead bands, `pwm_o` is 0 in ticks 0 to D-1 and 1 from tick D to the end of the period.
- R5: Lower dead band. If D < 16 with `mult16_i` = 1, or D < 8 with `mult16_i` = 0, `pwm_o` holds the resting level for the whole period.
- R6: Upper dead band. If D + 8 >= P, `pwm_o` holds the resting level for the whole period. This applies whatever `mult16_i` is, and it includes codes at or above P.
- R7: The active code, polarity, band select and period are sampled only at a period rollover. A code written in the middle of a period leaves the rest of that period unchanged and is used from the next tick 0.
- R8: While the active period is 0 or 1, the block is idle. `pwm_o` holds the resting level of the sampled polarity and `period_start_o` stays 0. A new period of 2 or more is sampled in the next cycle.
- R9: `duty_ready_o` is always 1. Every cycle with `duty_valid_i` = 1 overwrites the pending code, so the last code written before a rollover wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Period length in ticks, sampled at rollover |
| duty_i | input | CNT_W | Code to be loaded into the pending register |
| duty_valid_i | input | 1 | Code transfer request |
| duty_ready_o | output | 1 | Always 1; the block never applies back-pressure |
| mode_i | input | 1 | 0 = reset/set, 1 = set/reset polarity |
| mult16_i | input | 1 | 1 = 16-count lower dead band, 0 = 8-count lower dead band |
| pwm_o | output | 1 | Pulse output |
| period_start_o | output | 1 | High during tick 0 of each period |

## Verification
The bench targets the exact edges of both dead bands:
- codes 7 and 8 with the narrow band, and 15 and 16 with the wide band;
- P-9 and P-8 at the top, plus a code larger than the period.

A design with an off-by-one comparison would pulse for a whole period where it should rest, or the reverse. A code written in the middle of a period checks the shadowing: a design without it would cut the running pulse short. Back-to-back writes confirm that the latest code wins. Periods of 1 and 0 under both polarities check that an idle design holds the right resting level and emits no strobe.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  typedef enum logic {
    MODE_RST_SET = 1'b0,
    MODE_SET_RST = 1'b1
  } out_mode_e;

  localparam int unsigned LOW_BAND_NARROW = 8;
  localparam int unsigned LOW_BAND_WIDE   = 16;
  localparam int unsigned HIGH_BAND       = 8;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  output logic             load_o,
  output logic             running_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_period_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic             last_tick;

  assign running_o    = (per_q >= CNT_W'(2));
  assign last_tick    = (cnt_q == per_q - 1'b1);
  assign load_o       = !running_o || last_tick;
  assign cnt_o        = cnt_q;
  assign act_period_o = per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (load_o) begin
      cnt_q <= '0;
      per_q <= period_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_duty_regs.sv
module pwm_duty_regs
  import pwm_dac_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             duty_valid_i,
  input  logic             mode_i,
  input  logic             mult16_i,
  output logic [CNT_W-1:0] act_duty_o,
  output out_mode_e        act_mode_o,
  output logic             act_wide_o
);
  logic [CNT_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (duty_valid_i) begin
      shadow_q <= duty_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_duty_o <= '0;
      act_mode_o <= MODE_RST_SET;
      act_wide_o <= 1'b0;
    end else if (load_i) begin
      act_duty_o <= shadow_q;
      act_mode_o <= out_mode_e'(mode_i);
      act_wide_o <= mult16_i;
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_dac_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             running_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] act_period_i,
  input  logic [CNT_W-1:0] act_duty_i,
  input  out_mode_e        act_mode_i,
  input  logic             act_wide_i,
  output logic             pwm_o
);
  localparam int unsigned EW = CNT_W + 1;

  logic [EW-1:0] low_band;
  logic [EW-1:0] duty_ext;
  logic          dead_lo;
  logic          dead_hi;
  logic          rest_lvl;

  always_comb begin
    low_band = act_wide_i ? EW'(LOW_BAND_WIDE) : EW'(LOW_BAND_NARROW);
    duty_ext = {1'b0, act_duty_i};
    dead_lo  = (duty_ext < low_band);
    dead_hi  = ((duty_ext + EW'(HIGH_BAND)) >= {1'b0, act_period_i});
    rest_lvl = (act_mode_i == MODE_SET_RST);
    if (!running_i || dead_lo || dead_hi) begin
      pwm_o = rest_lvl;
    end else if (cnt_i < act_duty_i) begin
      pwm_o = !rest_lvl;
    end else begin
      pwm_o = rest_lvl;
    end
  end
endmodule

// File: rtl/pwm_dac_gen.sv
module pwm_dac_gen
  import pwm_dac_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             duty_valid_i,
  output logic             duty_ready_o,
  input  logic             mode_i,
  input  logic             mult16_i,
  output logic             pwm_o,
  output logic             period_start_o
);
  logic             load;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_period;
  logic [CNT_W-1:0] act_duty;
  out_mode_e        act_mode;
  logic             act_wide;

  assign duty_ready_o   = 1'b1;
  assign period_start_o = running && (cnt == '0);

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_i     (period_i),
    .load_o       (load),
    .running_o    (running),
    .cnt_o        (cnt),
    .act_period_o (act_period)
  );

  pwm_duty_regs #(.CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .duty_i       (duty_i),
    .duty_valid_i (duty_valid_i),
    .mode_i       (mode_i),
    .mult16_i     (mult16_i),
    .act_duty_o   (act_duty),
    .act_mode_o   (act_mode),
    .act_wide_o   (act_wide)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .running_i    (running),
    .cnt_i        (cnt),
    .act_period_i (act_period),
    .act_duty_i   (act_duty),
    .act_mode_i   (act_mode),
    .act_wide_i   (act_wide),
    .pwm_o        (pwm_o)
  );
endmodule

// File: rtl/pwm_dac_gen_chk.sv
module pwm_dac_gen_chk
  import pwm_dac_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pwm,
  input logic             running,
  input out_mode_e        act_mode,
  input logic [CNT_W-1:0] act_duty
);
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R3
  rs_rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm) && running && act_mode == MODE_RST_SET &&
     $past(act_mode) == MODE_RST_SET) |-> start);

  // R4
  sr_fall_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm) && running && act_mode == MODE_SET_RST &&
     $past(act_mode) == MODE_SET_RST) |-> start);

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |-> $stable(act_duty));

  // R8
  idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm == (act_mode == MODE_SET_RST)));
endmodule

bind pwm_dac_gen pwm_dac_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (period_start_o),
  .pwm      (pwm_o),
  .running  (running),
  .act_mode (act_mode),
  .act_duty (act_duty)
);

// File: tb/pwm_dac_gen_tb_top.sv
module pwm_dac_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] duty_i = '0;
  logic             duty_valid_i = 1'b0;
  logic             duty_ready_o;
  logic             mode_i = 1'b0;
  logic             mult16_i = 1'b0;
  logic             pwm_o;
  logic             period_start_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  bit    exp_pwm_q[$];
  bit    exp_st_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dac_gen #(.CNT_W(CNT_W)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .period_i       (period_i),
    .duty_i         (duty_i),
    .duty_valid_i   (duty_valid_i),
    .duty_ready_o   (duty_ready_o),
    .mode_i         (mode_i),
    .mult16_i       (mult16_i),
    .pwm_o          (pwm_o),
    .period_start_o (period_start_o)
  );

  function automatic bit exp_bit(int c, int p, int d, bit m, bit w);
    int band = w ? 16 : 8;
    if (d < band || d + 8 >= p) return m;
    return (c < d) ? !m : m;
  endfunction

  task automatic check(string tag, bit act, bit expv);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_pwm_q.size() > 0) begin
        automatic bit    ep = exp_pwm_q.pop_front();
        automatic bit    es = exp_st_q.pop_front();
        automatic string t  = tag_q.pop_front();
        check({t, " pwm"}, pwm_o, ep);
        check({t, " start"}, period_start_o, es);
      end
    end
  end

  task automatic set_cfg(int p, int d, bit m, bit w);
    @(negedge clk);
    period_i = CNT_W'(p); mode_i = m; mult16_i = w;
    duty_i = CNT_W'(d); duty_valid_i = 1'b1;
    @(negedge clk);
    duty_valid_i = 1'b0;
  endtask

  task automatic wait_start();
    @(negedge clk);
    while (!period_start_o) @(negedge clk);
  endtask

  // driver: align to a period, push one period of expectations
  task automatic run_period(int skips, int p, int d, bit m, bit w, string tag, int mid);
    for (int s = 0; s < skips; s++) wait_start();
    for (int c = 0; c < p; c++) begin
      exp_pwm_q.push_back(exp_bit(c, p, d, m, w));
      exp_st_q.push_back(c == 0);
      tag_q.push_back(tag);
    end
    for (int k = 1; k < p; k++) begin
      @(negedge clk);
      if (mid >= 0 && k == 3) begin
        duty_i = CNT_W'(mid); duty_valid_i = 1'b1;
      end else begin
        duty_valid_i = 1'b0;
      end
    end
  endtask

  task automatic cfg_check(int p, int d, bit m, bit w, string tag);
    set_cfg(p, d, m, w);
    run_period(2, p, d, m, w, tag, -1);
  endtask

  task automatic idle_check(bit m, int n, string tag);
    repeat (n) begin
      @(negedge clk);
      exp_pwm_q.push_back(m);
      exp_st_q.push_back(1'b0);
      tag_q.push_back(tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pwm", pwm_o, 1'b0);
    check("R1 reset start", period_start_o, 1'b0);
    check("R9 ready", duty_ready_o, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset pwm", pwm_o, 1'b0);

    cfg_check(32, 12, 0, 0, "R3 rs normal");
    cfg_check(32, 20, 1, 1, "R4 sr normal");
    cfg_check(32, 12, 0, 1, "R5 wide band rs");
    cfg_check(32, 12, 1, 1, "R5 wide band sr");
    cfg_check(32, 15, 0, 1, "R5 code 15 wide");
    cfg_check(32, 16, 0, 1, "R5 code 16 wide");
    cfg_check(32, 7, 1, 0, "R5 code 7 narrow");
    cfg_check(32, 8, 1, 0, "R5 code 8 narrow");
    cfg_check(32, 23, 0, 0, "R6 code P-9");
    cfg_check(32, 24, 0, 1, "R6 code P-8");
    cfg_check(64, 600, 1, 0, "R6 code above P");
    cfg_check(64, 40, 0, 0, "R2 period 64");

    // R7: mid-period write must not disturb the running period
    set_cfg(40, 20, 0, 0);
    run_period(2, 40, 20, 0, 0, "R7 current period", 10);
    run_period(1, 40, 10, 0, 0, "R7 next period", -1);

    // R9: back-to-back writes, latest wins
    @(negedge clk);
    check("R9 ready", duty_ready_o, 1'b1);
    duty_i = 10'd30; duty_valid_i = 1'b1;
    @(negedge clk);
    duty_i = 10'd11; duty_valid_i = 1'b1;
    @(negedge clk);
    duty_valid_i = 1'b0;
    run_period(2, 40, 11, 0, 0, "R9 latest wins", -1);

    // R8: idle periods
    set_cfg(1, 20, 1, 0);
    repeat (90) @(negedge clk);
    idle_check(1'b1, 12, "R8 idle P=1 sr");
    set_cfg(0, 20, 0, 0);
    repeat (4) @(negedge clk);
    idle_check(1'b0, 12, "R8 idle P=0 rs");
    cfg_check(24, 10, 1, 0, "R8 resume");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule